// File: doc/BRIEF.md
# Dual-Port RAM with Same-Word Collision Arbitration

This block is a synchronous two-port static memory. A left port and a right port each carry their own address, write data, read data, chip enable, write select and output enable. They run side by side on one clock, and each port can read or write any word in any cycle. The array holds 2**ADDR_W words of DATA_W bits. The full-size build sets ADDR_W to 13, which gives 8192 words, and DATA_W to 8 or 9. The defaults are smaller so that elaboration stays light.

When both ports reach the same word in one cycle and at least one of them writes, an arbiter picks one winner. The other port gets a busy flag, and its write, if any, is dropped. The master/slave select input decides where busy comes from. In master mode this block computes busy and drives it out. In slave mode the busy inputs come from a master block and only gate local writes. Several slave blocks can then follow one master to form a wider word. A port-idle flag shows when a port has neither its chip enable nor its semaphore select active.

Top module: `dpr_dual_ram`

## Requirements
- R1: A word written through one port at any address from 0 to 2**ADDR_W-1 can be read back unchanged through either port.
- R2: When both ports read the same address in the same cycle, neither busy output rises and both return the stored word.
- R3: In master mode, when both ports enable the same address and at least one writes, and neither held it in the cycle before, the left port wins. Right busy output is 1, left busy output is 0, and a write from the right port does not reach the array.
- R4: A read that loses a collision still completes and returns the word as it stood before the winning write.
- R5: A port that was enabled on an address without busy in the previous cycle, and still enables that same address, keeps priority there. A newly arriving left access then gets busy=1, and its write is dropped.
- R6: In slave mode (master select = 0), both busy outputs stay 0. A port whose busy input is 1 does not write, and a port whose busy input is 0 writes with no local arbitration.
- R7: Read data is all zeros unless, at the clock edge before, the port had chip enable = 1, output enable = 1 and write select = 0 (read).
- R8: Read data appears exactly one clock edge after the read request. In the cycle the request is presented, the output still shows the previous result.
- R9: The idle output of a port is 1 exactly when both its chip enable and its semaphore select are 0.
- R10: Writes from the two ports to different addresses in the same cycle both take effect, and no busy is raised.
- R11: After reset, both read data outputs and both busy outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ms_master_i | input | 1 | 1 = master (busy computed here), 0 = slave (busy taken in) |
| l_addr_i | input | ADDR_W | Left port word address |
| l_wdata_i | input | DATA_W | Left port write data |
| l_rdata_o | output | DATA_W | Left port registered read data, zero when not driven |
| l_cs_i | input | 1 | Left port chip enable, active high |
| l_we_i | input | 1 | Left port write select, 1 = write, 0 = read |
| l_oe_i | input | 1 | Left port output enable, active high |
| l_sem_i | input | 1 | Left port semaphore select, used only for idle status |
| l_busy_i | input | 1 | Left busy input, used in slave mode |
| l_busy_o | output | 1 | Left busy output, master mode only |
| l_idle_o | output | 1 | Left port idle |
| r_addr_i | input | ADDR_W | Right port word address |
| r_wdata_i | input | DATA_W | Right port write data |
| r_rdata_o | output | DATA_W | Right port registered read data, zero when not driven |
| r_cs_i | input | 1 | Right port chip enable, active high |
| r_we_i | input | 1 | Right port write select, 1 = write, 0 = read |
| r_oe_i | input | 1 | Right port output enable, active high |
| r_sem_i | input | 1 | Right port semaphore select, used only for idle status |
| r_busy_i | input | 1 | Right busy input, used in slave mode |
| r_busy_o | output | 1 | Right busy output, master mode only |
| r_idle_o | output | 1 | Right port idle |

## Verification
The single-writer assertion on the array assumes that in slave mode the external master never leaves both busy inputs low while both ports write one word. The stimulus uses slave mode only for a lone write or for a read against a write. The priority property assumes the master/slave select is steady for two cycles, so the bench changes it only while both ports are disabled. The read-path properties assume that read data is produced only from requests made after the internal reset release. The bench therefore holds every enable low until several cycles after reset is released.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int NPORT = 2;
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;
endpackage

// File: rtl/dpr_storage.sv
module dpr_storage #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [dpr_pkg::NPORT-1:0]             wr_en_i,
  input  logic [dpr_pkg::NPORT-1:0][ADDR_W-1:0] addr_i,
  input  logic [dpr_pkg::NPORT-1:0][DATA_W-1:0] wdata_i,
  output logic [dpr_pkg::NPORT-1:0][DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < dpr_pkg::NPORT; p++) begin
      if (wr_en_i[p]) begin
        mem_q[addr_i[p]] <= wdata_i[p];
      end
    end
  end

  for (genvar g = 0; g < dpr_pkg::NPORT; g++) begin : g_rd
    assign rdata_o[g] = mem_q[addr_i[g]];
  end

  // R3: arbitration must never let both ports write one word
  a_r3_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i[0] && wr_en_i[1] && (addr_i[0] == addr_i[1])));
endmodule

// File: rtl/dpr_collision_arb.sv
module dpr_collision_arb #(
  parameter int ADDR_W = 10
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [dpr_pkg::NPORT-1:0]             cs_i,
  input  logic [dpr_pkg::NPORT-1:0]             we_i,
  input  logic [dpr_pkg::NPORT-1:0][ADDR_W-1:0] addr_i,
  input  logic [dpr_pkg::NPORT-1:0]             hold_i,
  output logic [dpr_pkg::NPORT-1:0]             lose_o
);
  import dpr_pkg::*;

  logic same_word;
  logic collide;
  logic right_keeps;

  always_comb begin
    same_word   = (addr_i[SIDE_LEFT] == addr_i[SIDE_RIGHT]);
    collide     = cs_i[SIDE_LEFT] & cs_i[SIDE_RIGHT] & same_word
                  & (we_i[SIDE_LEFT] | we_i[SIDE_RIGHT]);
    right_keeps = hold_i[SIDE_RIGHT] & ~hold_i[SIDE_LEFT];
    lose_o[SIDE_LEFT]  = collide & right_keeps;
    lose_o[SIDE_RIGHT] = collide & ~right_keeps;
  end

  // R3: at most one side loses
  a_r3_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
    !(lose_o[0] && lose_o[1]));

  // R2: two reads of one word never cause busy
  a_r2_read_pair_free: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i[0] && cs_i[1] && !we_i[0] && !we_i[1]) |-> (lose_o == '0));
endmodule

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic              sem_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] arr_rd_i,
  output logic              wr_en_o,
  output logic              hold_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              idle_o
);
  logic              rd_req;
  logic              own_d, own_q;
  logic              drv_d, drv_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DATA_W-1:0] data_d, data_q;

  always_comb begin
    rd_req  = cs_i & ~we_i & oe_i;
    wr_en_o = cs_i & we_i & ~busy_i;
    hold_o  = cs_i & own_q & (addr_i == addr_q);
    idle_o  = ~cs_i & ~sem_i;
    own_d   = cs_i & ~busy_i;
    addr_d  = cs_i ? addr_i : addr_q;
    drv_d   = rd_req;
    data_d  = rd_req ? arr_rd_i : data_q;
    rdata_o = drv_q ? data_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      own_q <= own_d;
      drv_q <= drv_d;
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_d;
    data_q <= data_d;
  end

  // R8: a read request shows the array word one edge later
  a_r8_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rdata_o == $past(arr_rd_i)));
endmodule

// File: rtl/dpr_dual_ram.sv
module dpr_dual_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_master_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              l_cs_i,
  input  logic              l_we_i,
  input  logic              l_oe_i,
  input  logic              l_sem_i,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  output logic              l_idle_o,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  input  logic              r_cs_i,
  input  logic              r_we_i,
  input  logic              r_oe_i,
  input  logic              r_sem_i,
  input  logic              r_busy_i,
  output logic              r_busy_o,
  output logic              r_idle_o
);
  import dpr_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_s;

  logic [NPORT-1:0]             cs, we, oe, sem, busy_in, busy_eff;
  logic [NPORT-1:0]             lose, hold, wr_en, idle;
  logic [NPORT-1:0][ADDR_W-1:0] addr;
  logic [NPORT-1:0][DATA_W-1:0] wdata, arr_rd, rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign cs      = {r_cs_i,    l_cs_i};
  assign we      = {r_we_i,    l_we_i};
  assign oe      = {r_oe_i,    l_oe_i};
  assign sem     = {r_sem_i,   l_sem_i};
  assign busy_in = {r_busy_i,  l_busy_i};
  assign addr    = {r_addr_i,  l_addr_i};
  assign wdata   = {r_wdata_i, l_wdata_i};

  dpr_collision_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_s),
    .cs_i   (cs),
    .we_i   (we),
    .addr_i (addr),
    .hold_i (hold),
    .lose_o (lose)
  );

  always_comb begin
    busy_eff = ms_master_i ? lose : busy_in;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_s),
      .cs_i     (cs[p]),
      .we_i     (we[p]),
      .oe_i     (oe[p]),
      .sem_i    (sem[p]),
      .addr_i   (addr[p]),
      .busy_i   (busy_eff[p]),
      .arr_rd_i (arr_rd[p]),
      .wr_en_o  (wr_en[p]),
      .hold_o   (hold[p]),
      .rdata_o  (rdata[p]),
      .idle_o   (idle[p])
    );
  end

  dpr_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (arr_rd)
  );

  assign l_rdata_o = rdata[SIDE_LEFT];
  assign r_rdata_o = rdata[SIDE_RIGHT];
  assign l_busy_o  = ms_master_i & lose[SIDE_LEFT];
  assign r_busy_o  = ms_master_i & lose[SIDE_RIGHT];
  assign l_idle_o  = idle[SIDE_LEFT];
  assign r_idle_o  = idle[SIDE_RIGHT];

  // R5: a right port that kept its word without busy is not displaced
  a_r5_holder_keeps_word: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rst_s) && ms_master_i && $past(ms_master_i)
     && $past(r_cs_i && !r_busy_o) && r_cs_i && (r_addr_i == $past(r_addr_i))
     && !(l_cs_i && $past(l_cs_i && !l_busy_o) && (l_addr_i == $past(l_addr_i))))
    |-> !r_busy_o);

  // R7: read data is nonzero only after an enabled read request
  a_r7_quiet_unless_read: assert property (@(posedge clk) disable iff (!rst_s)
    (l_rdata_o != '0) |-> $past(l_cs_i && l_oe_i && !l_we_i));
endmodule

// File: tb/test_dpr_dual_ram.sv
`timescale 1ns/1ps
module test_dpr_dual_ram;
  localparam int AW = 10;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic ms;
  logic [AW-1:0] la, ra;
  logic [DW-1:0] lwd, rwd, lrd, rrd;
  logic lcs, lwe, loe, lsem, lbi, lbo, lidle;
  logic rcs, rwe, roe, rsem, rbi, rbo, ridle;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpr_dual_ram #(.ADDR_W(AW), .DATA_W(DW)) i_dpr_dual_ram (
    .clk(clk), .rst_n(rst_n), .ms_master_i(ms),
    .l_addr_i(la), .l_wdata_i(lwd), .l_rdata_o(lrd), .l_cs_i(lcs), .l_we_i(lwe),
    .l_oe_i(loe), .l_sem_i(lsem), .l_busy_i(lbi), .l_busy_o(lbo), .l_idle_o(lidle),
    .r_addr_i(ra), .r_wdata_i(rwd), .r_rdata_o(rrd), .r_cs_i(rcs), .r_we_i(rwe),
    .r_oe_i(roe), .r_sem_i(rsem), .r_busy_i(rbi), .r_busy_o(rbo), .r_idle_o(ridle)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    lcs = 0; lwe = 0; loe = 0; lsem = 0; lbi = 0; la = '0; lwd = '0;
    rcs = 0; rwe = 0; roe = 0; rsem = 0; rbi = 0; ra = '0; rwd = '0;
  endtask

  task automatic set_l(input logic w, input logic o, input logic [AW-1:0] a, input logic [DW-1:0] d);
    lcs = 1; lwe = w; loe = o; la = a; lwd = d;
  endtask

  task automatic set_r(input logic w, input logic o, input logic [AW-1:0] a, input logic [DW-1:0] d);
    rcs = 1; rwe = w; roe = o; ra = a; rwd = d;
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
    quiet(); set_l(1, 0, a, d); step(); quiet();
  endtask

  task automatic peek_l(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    quiet(); set_l(0, 1, a, '0); step(); chk(tag, lrd, exp); quiet();
  endtask

  task automatic t_reset();
    chk("R11 left rdata after reset", lrd, 0);
    chk("R11 right rdata after reset", rrd, 0);
    chk("R11 left busy after reset", lbo, 0);
    chk("R11 right busy after reset", rbo, 0);
  endtask

  task automatic t_basic();
    poke(10'd3, 9'h155);
    set_r(0, 1, 10'd3, '0);
    #1 chk("R8 right rdata before edge", rrd, 0);
    step();
    chk("R1 R8 right reads left write", rrd, 9'h155);
    quiet(); set_r(1, 0, 10'h3FF, 9'h1FF); step(); quiet();
    peek_l(10'h3FF, 9'h1FF, "R1 top address via left");
  endtask

  task automatic t_read_pair();
    poke(10'd7, 9'h0A3);
    step();
    set_l(0, 1, 10'd7, '0); set_r(0, 1, 10'd7, '0);
    #1 chk("R2 left busy on shared read", lbo, 0);
    chk("R2 right busy on shared read", rbo, 0);
    step();
    chk("R2 left data", lrd, 9'h0A3);
    chk("R2 right data", rrd, 9'h0A3);
    quiet();
  endtask

  task automatic t_write_read();
    poke(10'd9, 9'h011);
    step();
    set_l(1, 0, 10'd9, 9'h122); set_r(0, 1, 10'd9, '0);
    #1 chk("R3 right busy on write-read", rbo, 1);
    chk("R3 left busy on write-read", lbo, 0);
    step();
    chk("R4 loser read returns old word", rrd, 9'h011);
    peek_l(10'd9, 9'h122, "R3 winner write landed");
  endtask

  task automatic t_write_write();
    quiet(); step();
    set_l(1, 0, 10'd12, 9'h0F0); set_r(1, 0, 10'd12, 9'h10F);
    #1 chk("R3 right busy on double write", rbo, 1);
    step();
    peek_l(10'd12, 9'h0F0, "R3 right write dropped");
  endtask

  task automatic t_hold();
    poke(10'd20, 9'h033);
    step();
    set_r(0, 1, 10'd20, '0);
    step();
    set_l(1, 0, 10'd20, 9'h144);
    #1 chk("R5 newcomer left busy", lbo, 1);
    chk("R5 holder right not busy", rbo, 0);
    step();
    chk("R5 holder read data", rrd, 9'h033);
    peek_l(10'd20, 9'h033, "R5 newcomer write dropped");
  endtask

  task automatic t_slave();
    poke(10'd30, 9'h055);
    step();
    ms = 0;
    step();
    set_l(0, 1, 10'd30, '0); set_r(1, 0, 10'd30, 9'h0AA); rbi = 1;
    #1 chk("R6 slave left busy out", lbo, 0);
    chk("R6 slave right busy out", rbo, 0);
    step();
    quiet(); set_r(1, 0, 10'd31, 9'h0CC);
    step();
    quiet(); step();
    ms = 1;
    step();
    peek_l(10'd30, 9'h055, "R6 busy input blocked write");
    peek_l(10'd31, 9'h0CC, "R6 free slave write landed");
  endtask

  task automatic t_oe();
    poke(10'd40, 9'h0E7);
    set_l(0, 0, 10'd40, '0); step();
    chk("R7 output enable low", lrd, 0);
    set_l(0, 1, 10'd40, '0); step();
    chk("R7 output enable high", lrd, 9'h0E7);
    set_l(1, 1, 10'd41, 9'h001); step();
    chk("R7 write cycle output", lrd, 0);
    quiet();
  endtask

  task automatic t_idle();
    quiet(); #1;
    chk("R9 idle when unselected", lidle, 1);
    lsem = 1; #1;
    chk("R9 not idle with semaphore select", lidle, 0);
    lsem = 0; rcs = 1; #1;
    chk("R9 right not idle with chip enable", ridle, 0);
    quiet();
  endtask

  task automatic t_distinct();
    quiet(); step();
    set_l(1, 0, 10'd50, 9'h1AB); set_r(1, 0, 10'd51, 9'h0BA);
    #1 chk("R10 no busy left", lbo, 0);
    chk("R10 no busy right", rbo, 0);
    step();
    quiet(); set_l(0, 1, 10'd51, '0); set_r(0, 1, 10'd50, '0); step();
    chk("R10 right write landed", lrd, 9'h0BA);
    chk("R10 left write landed", rrd, 9'h1AB);
    quiet();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    quiet();
    ms = 1;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) step();
    t_reset();
    t_basic();
    t_read_pair();
    t_write_read();
    t_write_write();
    t_hold();
    t_slave();
    t_oe();
    t_idle();
    t_distinct();
    step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule